// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit registers that sits behind a simple word-wide register bus with select, write enable, address, write data and read data. It decodes a 4 KB byte window. The lower half of the window holds writable storage. Software reads and writes control words there. A few words come out of reset with fixed non-zero defaults.

Two kinds of offset have their own behaviour. One command offset sits in the unbacked upper half of the window. Writing a recognised code to it raises a one-cycle reset request or shutdown request, and the access is still reported as out of range. Three status offsets in the backed range always read back with two fixed bits set, whatever value is stored there. Any access above the backed range leaves storage unchanged and pulses the error output.

Every access finishes in one cycle. Read data, the error flag and the two request outputs are registered. They are valid in the cycle after the access is sampled.

Top module: `sysctl_regbank`

## Requirements
- R1: A write with `sel_i=1`, `wr_en_i=1` to a byte offset in 0x000..0x7FC stores `wdata_i` in word index offset/4. A later read of the same offset returns that value, with the R7 mask applied at the status offsets.
- R2: During reset and after it, `rdata_o`, `err_o`, `reset_req_o` and `shutdown_req_o` are 0. Word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other word holds 0.
- R3: A write of value 1 or 2 to byte offset 0xF00 makes `reset_req_o` high for exactly the one cycle after the write.
- R4: A write of value 3 to byte offset 0xF00 makes `shutdown_req_o` high for exactly the one cycle after the write. Any other value, or a command value written to any other offset, raises neither request.
- R5: A write to a byte offset of 0x800 or above, including 0xF00, changes no stored word and makes `err_o` high for the one cycle after the write.
- R6: A read of a byte offset of 0x800 or above returns 0 on `rdata_o` and makes `err_o` high for the one cycle after the read.
- R7: A read of byte offset 0x100, 0x108 or 0x10C returns the stored word OR 0x30000000, which sets bits 29 and 28. The stored word is not changed. Other offsets return the stored word unmasked.
- R8: Address bits 1:0 are ignored for storage, status masking, range checking and command decoding.
- R9: Read data appears on `rdata_o` in the cycle after a read access and holds until the next read. `err_o` is 0 after any in-range access and in cycles with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Access strobe, one access per cycle |
| wr_en_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an out-of-range access |
| reset_req_o | output | 1 | One-cycle system reset request |
| shutdown_req_o | output | 1 | One-cycle system shutdown request |

## Verification
The hardest case is an address that aliases. Offset 0x800 and offset 0xF00 share their low address bits with backed words 0x000 and 0x700. A decoder that drops the top address bit would write storage, or would fire a command from the wrong offset. To catch this, the stimulus writes marker values at the aliased offsets and then reads back the backed words. It also writes command codes at 0x700, 0xF04 and at 0xF00 with non-zero low address bits. Every response is compared each cycle against a behavioural model of the whole word array.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DATA_W = 32;

    // bits forced on when a status offset is read
    localparam logic [DATA_W-1:0] STATUS_OR_MASK = 32'h3000_0000;

    // byte offsets of the status words (word aligned)
    localparam int unsigned N_STATUS = 3;
    localparam logic [11:0] STATUS_OFS [N_STATUS] = '{12'h100, 12'h108, 12'h10C};

    // command codes written to the command offset
    localparam logic [DATA_W-1:0] CODE_RESET_A  = 32'd1;
    localparam logic [DATA_W-1:0] CODE_RESET_B  = 32'd2;
    localparam logic [DATA_W-1:0] CODE_SHUTDOWN = 32'd3;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic reset_req;
        logic shutdown_req;
    } cmd_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } bus_state_t;

    // default contents of a storage word after reset
    function automatic logic [DATA_W-1:0] word_default(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    function automatic cmd_kind_e classify_cmd(input logic [DATA_W-1:0] value);
        if (value == CODE_RESET_A || value == CODE_RESET_B) return CMD_RESET;
        if (value == CODE_SHUTDOWN)                         return CMD_SHUTDOWN;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DEPTH   = 512,
    parameter logic [11:0] CMD_OFS = 12'hF00,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned WORD_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic              in_range_o,
    output logic              is_cmd_o,
    output logic              is_status_o
);

    logic [WORD_W-1:0]   word_addr;
    logic [N_STATUS-1:0] status_hit;

    assign word_addr  = addr_i[ADDR_W-1:2];
    assign word_idx_o = addr_i[IDX_W+1:2];
    assign in_range_o = (32'(word_addr) < DEPTH);
    assign is_cmd_o   = (word_addr == CMD_OFS[ADDR_W-1:2]);

    for (genvar g = 0; g < N_STATUS; g++) begin : g_status
        assign status_hit[g] = (word_addr == STATUS_OFS[g][ADDR_W-1:2]);
    end

    assign is_status_o = |status_hit;

endmodule

// File: rtl/sysctl_storage.sv
module sysctl_storage
    import sysctl_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rword_o
);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[idx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= word_default(i);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rword_o = mem_q[idx_i];

    // R1: an accepted write lands in the addressed word
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(idx_i)] == $past(wdata_i)));

endmodule

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              reset_req_o,
    output logic              shutdown_req_o
);

    cmd_state_t st_d, st_q;
    cmd_kind_e  kind;

    always_comb begin
        kind = classify_cmd(value_i);
        st_d = '0;
        if (fire_i) begin
            st_d.reset_req    = (kind == CMD_RESET);
            st_d.shutdown_req = (kind == CMD_SHUTDOWN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reset_req_o    = st_q.reset_req;
    assign shutdown_req_o = st_q.shutdown_req;

    // R3: a reset request follows a command write carrying 1 or 2
    p_reset_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(fire_i && (value_i == 32'd1 || value_i == 32'd2)));

    // R4: a shutdown request follows a command write carrying 3
    p_shutdown_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_o |-> $past(fire_i && value_i == 32'd3));

    // R4: the two requests never overlap
    p_req_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_req_o, shutdown_req_o}));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DEPTH   = 512,
    parameter logic [11:0] CMD_OFS = 12'hF00,
    localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  err_o,
    output logic                  reset_req_o,
    output logic                  shutdown_req_o
);

    logic [IDX_W-1:0]  word_idx;
    logic              in_range;
    logic              is_cmd;
    logic              is_status;
    logic [DATA_W-1:0] stored_word;
    logic              store_we;
    logic              cmd_fire;

    bus_state_t st_d, st_q;

    sysctl_addr_decode #(
        .ADDR_W  (ADDR_W),
        .DEPTH   (DEPTH),
        .CMD_OFS (CMD_OFS)
    ) u_decode (
        .addr_i      (addr_i),
        .word_idx_o  (word_idx),
        .in_range_o  (in_range),
        .is_cmd_o    (is_cmd),
        .is_status_o (is_status)
    );

    assign store_we = sel_i && wr_en_i && in_range;
    assign cmd_fire = sel_i && wr_en_i && is_cmd;

    sysctl_storage #(
        .DEPTH (DEPTH)
    ) u_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .idx_i   (word_idx),
        .wdata_i (wdata_i),
        .rword_o (stored_word)
    );

    sysctl_cmd_decode u_cmd (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire_i         (cmd_fire),
        .value_i        (wdata_i),
        .reset_req_o    (reset_req_o),
        .shutdown_req_o (shutdown_req_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = sel_i && !in_range;
        if (sel_i && !wr_en_i) begin
            if (!in_range)      st_d.rdata = '0;
            else if (is_status) st_d.rdata = stored_word | STATUS_OR_MASK;
            else                st_d.rdata = stored_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign err_o   = st_q.err;

    // R5: the error flag only follows an access above the backed range
    p_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(sel_i && !in_range));

    // R6: an out-of-range read returns zero
    p_oob_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_en_i && !in_range) |=> (rdata_o == '0));

    // R7: status offsets always read with bits 29:28 set
    p_status_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_en_i && is_status) |=> (rdata_o[29:28] == 2'b11));

    // R9: read data holds when no read is issued
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && !wr_en_i) |=> $stable(rdata_o));

endmodule

// File: tb/sysctl_regbank_test.sv
`timescale 1ns/1ps
module sysctl_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        reset_req;
    logic        shutdown_req;

    int checks = 0;
    int fails  = 0;

    logic [31:0] model [512];
    logic [31:0] exp_rdata = '0;

    always #2.5 clk = ~clk;

    sysctl_regbank uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_i          (sel),
        .wr_en_i        (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .err_o          (err),
        .reset_req_o    (reset_req),
        .shutdown_req_o (shutdown_req)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, predict, then compare at the next falling edge
    task automatic step(input logic s, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        int  idx;
        bit  inr, on_cmd, on_stat;
        logic exp_err, exp_rst, exp_shut;
        sel = s; wr_en = w; addr = a; wdata = d;
        idx     = int'(a[11:2]);
        inr     = (idx < 512);
        on_cmd  = (a[11:2] == 10'h3C0);
        on_stat = (a[11:2] == 10'h040) || (a[11:2] == 10'h042) || (a[11:2] == 10'h043);
        exp_err  = s && !inr;
        exp_rst  = s && w && on_cmd && (d == 32'd1 || d == 32'd2);
        exp_shut = s && w && on_cmd && (d == 32'd3);
        if (s && !w) exp_rdata = inr ? (model[idx] | (on_stat ? 32'h3000_0000 : 32'h0)) : 32'h0;
        if (s && w && inr) model[idx] = d;
        @(negedge clk);
        check(tag, "rdata", rdata, exp_rdata);
        check(tag, "err", {31'b0, err}, {31'b0, exp_err});
        check(tag, "reset_req", {31'b0, reset_req}, {31'b0, exp_rst});
        check(tag, "shutdown_req", {31'b0, shutdown_req}, {31'b0, exp_shut});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 12'h0, 32'h0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin : stimulus
        for (int i = 0; i < 512; i++) model[i] = 32'h0;
        model[32'h40] = 32'h05F2_0121;
        model[32'h41] = 32'h0000_0002;
        model[32'h42] = 32'h05F3_0121;
        model[32'h43] = 32'h05F4_0121;

        // reset state (R2)
        repeat (3) @(negedge clk);
        check("R2", "rdata in reset", rdata, 32'h0);
        check("R2", "err in reset", {31'b0, err}, 32'h0);
        check("R2", "reset_req in reset", {31'b0, reset_req}, 32'h0);
        check("R2", "shutdown_req in reset", {31'b0, shutdown_req}, 32'h0);
        rst_n = 1'b1;
        idle("R2");

        // defaults and status masking (R2, R7)
        rd(12'h100, "R2 R7");
        rd(12'h104, "R2");
        rd(12'h108, "R2 R7");
        rd(12'h10C, "R2 R7");
        rd(12'h000, "R2");
        rd(12'h7FC, "R2");
        rd(12'h0FC, "R2");
        rd(12'h110, "R2");

        // store and read back a spread of words (R1)
        for (int i = 0; i < 24; i++) begin
            wr(12'((i * 37 % 512) * 4), (32'(i) * 32'h0123_4567) ^ 32'hA5A5_5A5A, "R1");
        end
        for (int i = 0; i < 24; i++) begin
            rd(12'((i * 37 % 512) * 4), "R1");
        end
        wr(12'h7FC, 32'hDEAD_BEEF, "R1");
        rd(12'h7FC, "R1");
        wr(12'h000, 32'hFFFF_FFFF, "R1");
        rd(12'h000, "R1");

        // status words keep their stored value (R7)
        wr(12'h100, 32'h0, "R7");
        rd(12'h100, "R7");
        wr(12'h108, 32'hCFFF_FFFF, "R7");
        rd(12'h108, "R7");
        wr(12'h104, 32'h0000_1234, "R7");
        rd(12'h104, "R7");

        // low address bits ignored (R8)
        wr(12'h203, 32'h1357_9BDF, "R8");
        rd(12'h200, "R8");
        rd(12'h201, "R8");
        rd(12'h10E, "R8 R7");

        // out-of-range writes and reads; aliases of backed words (R5, R6)
        wr(12'h800, 32'h1111_1111, "R5");
        rd(12'h000, "R5");
        wr(12'hFFC, 32'h2222_2222, "R5");
        rd(12'h7FC, "R5");
        wr(12'hD00, 32'h3333_3333, "R5");
        rd(12'h500, "R5");
        rd(12'h800, "R6");
        rd(12'hF00, "R6");
        rd(12'hFFF, "R6");
        idle("R9");
        idle("R9");

        // commands (R3, R4, R5)
        wr(12'hF00, 32'd1, "R3 R5");
        idle("R3");
        wr(12'hF00, 32'd2, "R3");
        wr(12'hF00, 32'd3, "R4");
        idle("R4");
        wr(12'hF00, 32'd0, "R4");
        wr(12'hF00, 32'd4, "R4");
        wr(12'hF00, 32'h0000_0101, "R4");
        wr(12'hF00, 32'hFFFF_FFFF, "R4");
        wr(12'hF04, 32'd1, "R4");
        wr(12'h700, 32'd3, "R4");
        rd(12'h700, "R5");
        wr(12'hF02, 32'd3, "R8 R4");
        wr(12'hF03, 32'd2, "R8 R3");
        rd(12'h000, "R5");
        step(1'b0, 1'b1, 12'hF00, 32'd1, "R3");
        idle("R9");
        rd(12'h104, "R9");
        wr(12'h104, 32'h0, "R9");
        idle("R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule